// File: doc/BRIEF.md
# Programmable Logic Output Cell

This block is a single output cell of a small sum-of-products programmable logic device. The surrounding AND/OR array hands it an already-formed sum term and an output-enable term. It also receives two terms shared by every registered cell: an asynchronous clear and a synchronous preset. From these and two configuration bits, the cell produces a pin value with its enable, and returns a feedback pair (true and complement) to the array.

The two configuration bits pick one of four modes:

| Mode | Pin source | Pin polarity |
|------|------------|--------------|
| `PM_REG_LOW` | stored bit | inverted |
| `PM_REG_HIGH` | stored bit | true |
| `PM_COMB_LOW` | live sum term | inverted |
| `PM_COMB_HIGH` | live sum term | true |

The stored bit lives in a one-bit state register with two states, cleared (Q0) and set (Q1). It moves between them as follows:

- The rising clock loads the sum term.
- The preset term forces Q1 at a clock edge.
- The clear term forces Q0 at once.

The mode itself takes no clock: any change of the configuration bits moves the cell to the matching mode in the same instant.

Clear and preset act on the stored bit before any inversion, so the pin level after a clear depends on the polarity chosen. In the two registered modes the array sees the stored bit, and the pin is a pure output. In the two combinatorial modes the array sees the pin level read back from the pad, so with the enable off the pin serves as an input.

Top module: `plm_outcell`

## Requirements
- R1: `cfg_comb`=0 selects a registered mode and `cfg_comb`=1 a combinatorial mode; `cfg_pol`=1 drives the pin with the source value unchanged, `cfg_pol`=0 drives its inverse.
- R2: With `ar_term` and `sp_term` low, each rising `clk` edge loads `sum_term` into the stored bit; in registered modes `pin_out` reflects the stored bit through the polarity and changes only after an edge.
- R3: In combinatorial modes `pin_out` follows `sum_term` through the polarity with no clock edge needed.
- R4: While `ar_term` is high the stored bit is 0, taking effect immediately without a clock edge.
- R5: `sp_term` high at a rising `clk` edge (with `ar_term` low) sets the stored bit to 1.
- R6: With `ar_term` and `sp_term` both high, the clear wins and the stored bit stays 0.
- R7: Clear and preset act before polarity: after a clear in a registered mode, `pin_out` is 0 when `cfg_pol`=1 and 1 when `cfg_pol`=0.
- R8: `pin_oe` equals `oe_term` in every mode, without a clock.
- R9: In registered modes `fb_true` is the stored bit and `fb_comp` its inverse, whatever `pin_in` is.
- R10: In combinatorial modes `fb_true` equals `pin_in` and `fb_comp` its inverse, whatever `sum_term` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock, rising edge |
| cfg_comb | input | 1 | Mode bit: 0 registered, 1 combinatorial |
| cfg_pol | input | 1 | Polarity bit: 1 true, 0 inverted |
| sum_term | input | 1 | Sum-of-products value from the array |
| oe_term | input | 1 | Output-enable product term |
| ar_term | input | 1 | Shared asynchronous clear, active high |
| sp_term | input | 1 | Shared synchronous preset, active high |
| pin_in | input | 1 | Level read back from the pad |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Pad driver enable |
| fb_true | output | 1 | Feedback to the array, true form |
| fb_comp | output | 1 | Feedback to the array, complement form |

## Verification
Every cycle, the assertions check the following:

- the state register's response to clear, preset and data loading;
- the priority of clear over preset;
- the fixed relation between pin and feedback in registered modes;
- the pin-sourced feedback in combinatorial modes.

Only the bench's scenarios can show what happens between clock edges. These are the immediate effect of a clear, the clock-free following of the sum term in combinatorial modes, and the pin level after a clear under each polarity. A sweep over every combination of mode, polarity and term values compares all four outputs with an arithmetic model.

// File: rtl/plm_pkg.sv
package plm_pkg;
    // Encoding is {cfg_comb, cfg_pol}
    typedef enum logic [1:0] {
        PM_REG_LOW   = 2'b00,
        PM_REG_HIGH  = 2'b01,
        PM_COMB_LOW  = 2'b10,
        PM_COMB_HIGH = 2'b11
    } plm_mode_e;

    typedef struct packed {
        logic comb;
        logic invert;
    } plm_path_t;
endpackage

// File: rtl/plm_mode_decode.sv
module plm_mode_decode
    import plm_pkg::*;
(
    input  logic      cfg_comb,
    input  logic      cfg_pol,
    output plm_mode_e mode,
    output plm_path_t path
);
    always_comb begin
        mode = plm_mode_e'({cfg_comb, cfg_pol});
    end

    always_comb begin
        unique case (mode)
            PM_REG_LOW:   path = '{comb: 1'b0, invert: 1'b1};
            PM_REG_HIGH:  path = '{comb: 1'b0, invert: 1'b0};
            PM_COMB_LOW:  path = '{comb: 1'b1, invert: 1'b1};
            PM_COMB_HIGH: path = '{comb: 1'b1, invert: 1'b0};
            default:      path = '{comb: 1'b0, invert: 1'b0};
        endcase
    end
endmodule

// File: rtl/plm_state_flop.sv
module plm_state_flop #(
    parameter logic CLEAR_VAL = 1'b0
) (
    input  logic clk,
    input  logic clr_a,
    input  logic set_s,
    input  logic d,
    output logic q
);
    localparam logic SET_VAL = ~CLEAR_VAL;

    always_ff @(posedge clk or posedge clr_a) begin
        if (clr_a)
            q <= CLEAR_VAL;
        else if (set_s)
            q <= SET_VAL;
        else
            q <= d;
    end

    // R4: clear holds the stored bit low
    a_r4_clear_holds: assert property (@(posedge clk) clr_a |-> (q == CLEAR_VAL));
    // R6: clear wins over preset
    a_r6_clear_priority: assert property (@(posedge clk) (clr_a && set_s) |-> (q == CLEAR_VAL));
    // R5: preset at an edge sets the bit
    a_r5_preset_sets: assert property (@(posedge clk) disable iff (clr_a)
        set_s |=> (q == SET_VAL));
    // R2: plain edge loads data
    a_r2_loads_data: assert property (@(posedge clk) disable iff (clr_a)
        !set_s |=> (q == $past(d)));
endmodule

// File: rtl/plm_route.sv
module plm_route
    import plm_pkg::*;
(
    input  plm_path_t path,
    input  logic      sum_term,
    input  logic      q,
    input  logic      pin_in,
    input  logic      oe_term,
    output logic      pin_out,
    output logic      pin_oe,
    output logic      fb_true,
    output logic      fb_comp
);
    logic drive_src;
    logic fb_src;

    always_comb begin
        drive_src = path.comb ? sum_term : q;
        pin_out   = drive_src ^ path.invert;
        fb_src    = path.comb ? pin_in : q;
        fb_true   = fb_src;
        fb_comp   = ~fb_src;
        pin_oe    = oe_term;
    end
endmodule

// File: rtl/plm_outcell.sv
module plm_outcell
    import plm_pkg::*;
(
    input  logic clk,
    input  logic cfg_comb,
    input  logic cfg_pol,
    input  logic sum_term,
    input  logic oe_term,
    input  logic ar_term,
    input  logic sp_term,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic fb_true,
    output logic fb_comp
);
    plm_mode_e mode;
    plm_path_t path;
    logic      q;

    plm_mode_decode u_dec (
        .cfg_comb (cfg_comb),
        .cfg_pol  (cfg_pol),
        .mode     (mode),
        .path     (path)
    );

    plm_state_flop #(.CLEAR_VAL(1'b0)) u_flop (
        .clk   (clk),
        .clr_a (ar_term),
        .set_s (sp_term),
        .d     (sum_term),
        .q     (q)
    );

    plm_route u_route (
        .path     (path),
        .sum_term (sum_term),
        .q        (q),
        .pin_in   (pin_in),
        .oe_term  (oe_term),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .fb_true  (fb_true),
        .fb_comp  (fb_comp)
    );

    // R9: registered feedback agrees with the pin through the polarity
    a_r9_reg_feedback: assert property (@(posedge clk) disable iff (ar_term)
        (mode == PM_REG_HIGH || mode == PM_REG_LOW) |-> (fb_true == (cfg_pol ? pin_out : !pin_out)));
    // R10: combinatorial feedback comes from the pad
    a_r10_comb_feedback: assert property (@(posedge clk) disable iff (ar_term)
        cfg_comb |-> (fb_true == pin_in && fb_comp == !pin_in));
    // R1: combinatorial pin matches sum term exactly when polarity is true
    a_r1_comb_polarity: assert property (@(posedge clk) disable iff (ar_term)
        cfg_comb |-> ((pin_out == sum_term) == cfg_pol));
endmodule

// File: tb/plm_outcell_bench.sv
module plm_outcell_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic cfg_comb, cfg_pol, sum_term, oe_term, ar_term, sp_term, pin_in;
    logic pin_out, pin_oe, fb_true, fb_comp;
    int   n_checks = 0;
    int   n_errors = 0;
    logic mq;

    always #(CLK_PERIOD/2) clk = ~clk;

    plm_outcell u_plm_outcell (
        .clk(clk), .cfg_comb(cfg_comb), .cfg_pol(cfg_pol), .sum_term(sum_term),
        .oe_term(oe_term), .ar_term(ar_term), .sp_term(sp_term), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_true(fb_true), .fb_comp(fb_comp)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic src, fbs;
        string tp;
        src = cfg_comb ? sum_term : mq;
        fbs = cfg_comb ? pin_in : mq;
        if (cfg_comb) tp = "R3 comb pin";
        else if (ar_term && sp_term) tp = "R6 clear over preset";
        else if (ar_term) tp = "R4 clear pin";
        else tp = "R2 registered pin";
        chk(pin_out, cfg_pol ? src : ~src, tp);
        chk(pin_oe, oe_term, "R8 enable");
        chk(fb_true, fbs, cfg_comb ? "R10 fb_true" : "R9 fb_true");
        chk(fb_comp, ~fbs, cfg_comb ? "R10 fb_comp" : "R9 fb_comp");
    endtask

    task automatic apply(input logic [6:0] v);
        @(negedge clk);
        {cfg_comb, cfg_pol, sum_term, oe_term, ar_term, sp_term, pin_in} = v;
        if (ar_term) mq = 1'b0;
        #1 check_all();
        @(posedge clk);
        if (ar_term) mq = 1'b0;
        else if (sp_term) mq = 1'b1;
        else mq = sum_term;
        #1 check_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        {cfg_comb, cfg_pol, sum_term, oe_term, sp_term, pin_in} = '0;
        ar_term = 1'b1;
        mq = 1'b0;
        #1;
        // R4 / R7: reset state, immediate clear, pin level per polarity
        chk(fb_true, 1'b0, "R4 clear before any edge");
        chk(pin_out, 1'b1, "R7 cleared pin with inverted polarity");
        cfg_pol = 1'b1;
        #1 chk(pin_out, 1'b0, "R7 cleared pin with true polarity");
        // R5: preset at edge
        @(negedge clk); ar_term = 1'b0; sp_term = 1'b1;
        @(posedge clk); #1 chk(fb_true, 1'b1, "R5 preset sets bit");
        // R6: clear wins, immediately
        @(negedge clk); ar_term = 1'b1;
        #1 chk(fb_true, 1'b0, "R6 clear immediate over preset");
        @(posedge clk); #1 chk(fb_true, 1'b0, "R6 clear holds at edge");
        // R1 / R3: comb mode follows sum without edge
        @(negedge clk); ar_term = 1'b0; sp_term = 1'b0; cfg_comb = 1'b1; sum_term = 1'b1;
        #1 chk(pin_out, 1'b1, "R1 true polarity comb");
        cfg_pol = 1'b0;
        #1 chk(pin_out, 1'b0, "R1 inverted polarity comb");
        sum_term = 1'b0;
        #1 chk(pin_out, 1'b1, "R3 comb follows sum without clock");
        mq = 1'b0;
        // Exhaustive sweeps in two orders
        for (int i = 0; i < 128; i++) apply(7'(i));
        for (int i = 127; i >= 0; i--) apply(7'(i ^ 7'h2a));
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule